// File: doc/BRIEF.md
# Offset and Gain Calibration Controller

This block runs black-level and white-level calibration for a three-colour imaging front end. A `start` pulse makes it write power-on defaults to the six channel registers: three offset codes and three gain codes. It then collects one dark line of converter samples and lowers each channel's offset code by that channel's measured dark level. Next it collects one white line. If every channel is already close to full scale, calibration ends. If not, it computes new gain codes, writes them, and goes back to the dark line.

Each sample is 12 bits of straight binary and arrives with a colour tag. Line boundaries are marked by single-cycle start and end strobes. Register writes go out one at a time over a request/acknowledge pair. The result is reported on two level outputs, `done` and `fail`. Both hold their value until the next `start`.

The offset DAC spans 200 mV in 256 straight-binary steps, and code C0h gives zero offset. The gain law is G = 40/(40 − X) for a 5-bit code X. A new code therefore comes from the current code and the white average. No lookup table is needed.

Top module: `cal_ctrl`

## Requirements
- R1: `start` is accepted only while the block is idle, done or failed. When accepted, it clears `done` and `fail` and issues six writes in ascending address order: addresses 1, 2, 3 (red, green, blue offset) with data C0h, then addresses 4, 5, 6 (red, green, blue gain) with data 00h. A `start` pulse during a calibration has no effect.
- R2: While `wr_req` is high, `wr_addr` and `wr_data` stay stable until the cycle in which `wr_ack` is high. Only one write is outstanding at a time.
- R3: A line runs from the first cycle with `line_start` high (after the block becomes ready) to the cycle with `line_end` high. Samples outside a line are ignored. Within a line, a sample counts when `smp_valid` is high and `smp_chan` is 0 (red), 1 (green) or 2 (blue); channel code 3 is ignored. Only the first 64 counted samples of each channel contribute, and the channel average is their sum divided by 64, rounded down.
- R4: After a dark line, each offset code becomes old − floor((5·avg + 4)/8), with a floor of 0. The three codes are then written to addresses 1, 2 and 3.
- R5: After a white line, if every channel average satisfies 100·avg ≥ 98·4095 (that is, avg ≥ 4014), `done` rises and no gain write is issued.
- R6: Otherwise each gain code becomes 40 − floor((40 − X_old)·avg/4095), limited to at most 31. The codes are written to addresses 4, 5 and 6, and a new dark line is awaited.
- R7: If the fourth white line since `start` still misses the R5 threshold, `fail` rises instead of any gain write, and no further writes follow.
- R8: While reset is active and right after it, `wr_req`, `done` and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 12 | Converter sample, straight binary |
| smp_chan | input | 2 | Colour tag: 0 red, 1 green, 2 blue, 3 none |
| line_start | input | 1 | First cycle of a line |
| line_end | input | 1 | Last cycle of a line |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 3 | Register address (1..3 offset, 4..6 gain) |
| wr_data | output | 8 | Register data |
| wr_ack | input | 1 | Write accepted in this cycle |
| done | output | 1 | Calibration converged |
| fail | output | 1 | Calibration gave up |

## Verification
Each register value the block holds leaves it only as the data of a later write. A wrong accumulator, average or code update therefore shows up in the first offset or gain write after the line that used it, two cycles after `line_end`. A wrong sequencing state shows up as a write to an unexpected address, as a missing write, or as `done` or `fail` rising in the wrong iteration. The bench models the analog path (gain law and clamp at full scale) so that the loop is driven the way a real scan would drive it, and it predicts every write address and data word in order.

// File: rtl/cal_ctrl.sv
module cal_ctrl #(
  parameter int SAMPLE_W = 12,
  parameter int AVG_LOG2 = 6,
  parameter int MAX_ITER = 4,
  parameter int NEAR_PCT = 2,
  parameter int OFF_W    = 8,
  parameter int GAIN_W   = 5,
  parameter int OFF_ZERO = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [1:0]          smp_chan,
  input  logic                line_start,
  input  logic                line_end,
  output logic                wr_req,
  output logic [2:0]          wr_addr,
  output logic [OFF_W-1:0]    wr_data,
  input  logic                wr_ack,
  output logic                done,
  output logic                fail
);
  localparam int SUM_W = SAMPLE_W + AVG_LOG2;
  localparam int CNT_W = AVG_LOG2 + 1;
  localparam int IT_W  = $clog2(MAX_ITER) + 1;
  localparam logic [31:0] FULL  = 32'((1 << SAMPLE_W) - 1);
  localparam logic [31:0] LAW   = 32'd40;
  localparam logic [31:0] GMAX  = 32'((1 << GAIN_W) - 1);
  localparam logic [31:0] NEED  = FULL * 32'(100 - NEAR_PCT);
  localparam logic [CNT_W-1:0] NSMP = CNT_W'(1 << AVG_LOG2);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WAIT, S_ACC, S_CALC, S_END} st_t;
  st_t st;

  logic [OFF_W-1:0]  off   [3];
  logic [GAIN_W-1:0] gn    [3];
  logic [OFF_W-1:0]  off_nx[3];
  logic [GAIN_W-1:0] gn_nx [3];
  logic [SUM_W-1:0]  sum   [3];
  logic [CNT_W-1:0]  cnt   [3];
  logic [2:0]        near;
  logic [2:0]        wlast;
  logic [IT_W-1:0]   iter;
  logic              white;

  wire first = (st == S_WAIT) && line_start;
  wire inacc = (st == S_ACC);

  for (genvar c = 0; c < 3; c++) begin : g_ch
    wire hit = smp_valid && (smp_chan == 2'(c));
    logic [31:0] avg, adj, q, t;
    assign avg = 32'(sum[c] >> AVG_LOG2);
    assign adj = (avg * 32'd5 + 32'd4) >> 3;
    assign q   = ((LAW - 32'(gn[c])) * avg) / FULL;
    assign t   = LAW - q;
    assign off_nx[c] = (adj > 32'(off[c])) ? '0 : OFF_W'(32'(off[c]) - adj);
    assign gn_nx[c]  = (t > GMAX) ? GAIN_W'(GMAX) : GAIN_W'(t);
    assign near[c]   = (avg * 32'd100) >= NEED;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sum[c] <= '0;
        cnt[c] <= '0;
      end else if (first) begin
        sum[c] <= hit ? SUM_W'(smp_data) : '0;
        cnt[c] <= hit ? CNT_W'(1) : '0;
      end else if (inacc && hit && cnt[c] < NSMP) begin
        sum[c] <= sum[c] + SUM_W'(smp_data);
        cnt[c] <= cnt[c] + 1'b1;
      end
    end
  end

  assign wr_req = (st == S_WR);
  always_comb begin
    wr_data = '0;
    if (wr_addr >= 3'd1 && wr_addr <= 3'd3) wr_data = off[wr_addr - 3'd1];
    else if (wr_addr >= 3'd4 && wr_addr <= 3'd6) wr_data = OFF_W'(gn[wr_addr - 3'd4]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      fail <= 1'b0;
      iter <= '0;
      white <= 1'b0;
      wr_addr <= 3'd1;
      wlast <= 3'd6;
      for (int c = 0; c < 3; c++) begin
        off[c] <= OFF_W'(OFF_ZERO);
        gn[c]  <= '0;
      end
    end else begin
      case (st)
        S_IDLE, S_END: if (start) begin
          done <= 1'b0;
          fail <= 1'b0;
          iter <= '0;
          wr_addr <= 3'd1;
          wlast <= 3'd6;
          for (int c = 0; c < 3; c++) begin
            off[c] <= OFF_W'(OFF_ZERO);
            gn[c]  <= '0;
          end
          st <= S_WR;
        end
        S_WR: if (wr_ack) begin
          if (wr_addr == wlast) begin
            white <= (wlast == 3'd3);
            st <= S_WAIT;
          end else begin
            wr_addr <= wr_addr + 3'd1;
          end
        end
        S_WAIT: if (line_start) st <= S_ACC;
        S_ACC:  if (line_end) st <= S_CALC;
        S_CALC: begin
          if (!white) begin
            for (int c = 0; c < 3; c++) off[c] <= off_nx[c];
            wr_addr <= 3'd1;
            wlast <= 3'd3;
            st <= S_WR;
          end else if (&near) begin
            done <= 1'b1;
            st <= S_END;
          end else if (iter == IT_W'(MAX_ITER - 1)) begin
            fail <= 1'b1;
            st <= S_END;
          end else begin
            for (int c = 0; c < 3; c++) gn[c] <= gn_nx[c];
            iter <= iter + 1'b1;
            wr_addr <= 3'd4;
            wlast <= 3'd6;
            st <= S_WR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cal_ctrl_chk.sv
module cal_ctrl_chk #(parameter int OFF_W = 8) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             wr_req,
  input logic [2:0]       wr_addr,
  input logic [OFF_W-1:0] wr_data,
  input logic             wr_ack,
  input logic             done,
  input logic             fail
);
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_addr >= 3'd1 && wr_addr <= 3'd6));

  assert_gain_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_addr >= 3'd4 |-> wr_data <= OFF_W'(31));

  assert_fail_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail && !wr_req);

  assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && !wr_req);

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
endmodule

bind cal_ctrl cal_ctrl_chk #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/cal_ctrl_tb.sv
module cal_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic [1:0]  smp_chan = '0;
  logic        line_start = 1'b0;
  logic        line_end = 1'b0;
  logic        wr_ack = 1'b0;
  logic        wr_req, done, fail;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cal_ctrl u_dut (.*);

  // per scenario: dark R,G,B then raw white R,G,B
  localparam int NSC = 4;
  localparam int VEC [NSC][6] = '{
    '{80, 100, 120, 2048, 3000, 1500},
    '{4095, 4095, 4095, 100, 100, 100},
    '{0, 0, 0, 4095, 4014, 4050},
    '{8, 16, 3, 4095, 4013, 4095}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_off(input int old, input int avg);
    int n = old - (5 * avg + 4) / 8;
    return (n < 0) ? 0 : n;
  endfunction

  function automatic int exp_gn(input int old, input int avg);
    int n = 40 - ((40 - old) * avg) / 4095;
    return (n > 31) ? 31 : n;
  endfunction

  function automatic int model_white(input int raw, input int x);
    int v = raw * 40 / (40 - x);
    return (v > 4095) ? 4095 : v;
  endfunction

  task automatic exp_wr(input int a, input int d, input string tag);
    int n = 0;
    logic [2:0] sa;
    logic [7:0] sd;
    while (!wr_req && n < 100) begin @(negedge clk); n++; end
    chk({tag, " req"}, int'(wr_req), 1);
    chk({tag, " addr"}, int'(wr_addr), a);
    chk({tag, " data"}, int'(wr_data), d);
    sa = wr_addr; sd = wr_data;
    repeat (a % 3) @(negedge clk);
    chk("R2 held until ack", int'(wr_req && wr_addr == sa && wr_data == sd), 1);
    wr_ack = 1'b1;
    @(negedge clk);
    wr_ack = 1'b0;
  endtask

  task automatic send_line(input int v0, input int v1, input int v2, input bit poke);
    int v[3];
    v[0] = v0; v[1] = v1; v[2] = v2;
    // R3: stray samples before line_start must be ignored
    repeat (2) begin
      smp_valid = 1'b1; smp_chan = 2'd0; smp_data = 12'hFFF;
      @(negedge clk);
    end
    for (int i = 0; i < 3 * 66; i++) begin
      int c = i % 3;
      int k = i / 3;
      if (i == 10) begin
        smp_valid = 1'b1; smp_chan = 2'd3; smp_data = 12'hFFF;
        @(negedge clk);
      end
      if (i == 20) begin
        smp_valid = 1'b0; smp_chan = 2'd1; smp_data = 12'hFFF;
        @(negedge clk);
      end
      start = poke && (i == 5);
      line_start = (i == 0);
      line_end = (i == 3 * 66 - 1);
      smp_valid = 1'b1;
      smp_chan = 2'(c);
      smp_data = (k < 64) ? 12'(v[c]) : 12'hFFF;
      @(negedge clk);
    end
    start = 1'b0; line_start = 1'b0; line_end = 1'b0;
    smp_valid = 1'b0; smp_data = '0; smp_chan = '0;
  endtask

  task automatic wait_evt();
    int n = 0;
    while (!(wr_req || done || fail) && n < 40) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int moff[3];
    int mgn[3];
    int w[3];
    repeat (3) @(negedge clk);
    chk("R8 req in reset", int'(wr_req), 0);
    chk("R8 done in reset", int'(done), 0);
    chk("R8 fail in reset", int'(fail), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 idle after reset", int'(wr_req || done || fail), 0);

    for (int s = 0; s < NSC; s++) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 flags cleared", int'(done || fail), 0);
      for (int c = 0; c < 3; c++) begin moff[c] = 192; mgn[c] = 0; end
      for (int c = 0; c < 3; c++) exp_wr(c + 1, 192, "R1 default offset");
      for (int c = 0; c < 3; c++) exp_wr(c + 4, 0, "R1 default gain");
      for (int it = 0; it < 4; it++) begin
        // R1: start pulse inside the first dark line of scenario 0 is ignored
        send_line(VEC[s][0], VEC[s][1], VEC[s][2], (s == 0 && it == 0));
        for (int c = 0; c < 3; c++) moff[c] = exp_off(moff[c], VEC[s][c]);
        for (int c = 0; c < 3; c++) exp_wr(c + 1, moff[c], "R3 R4 offset write");
        for (int c = 0; c < 3; c++) w[c] = model_white(VEC[s][3 + c], mgn[c]);
        send_line(w[0], w[1], w[2], 1'b0);
        wait_evt();
        if (w[0] >= 4014 && w[1] >= 4014 && w[2] >= 4014) begin
          chk("R5 done", int'(done), 1);
          chk("R5 no gain write", int'(wr_req || fail), 0);
          break;
        end
        if (it == 3) begin
          chk("R7 fail", int'(fail), 1);
          chk("R7 not done", int'(done), 0);
          repeat (10) @(negedge clk);
          chk("R7 no write after fail", int'(wr_req), 0);
          break;
        end
        chk("R5 not done below threshold", int'(done || fail), 0);
        for (int c = 0; c < 3; c++) mgn[c] = exp_gn(mgn[c], w[c]);
        for (int c = 0; c < 3; c++) exp_wr(c + 4, mgn[c], "R6 gain write");
      end
      repeat (3) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule